// File: doc/BRIEF.md
# ADC Trigger and Sequencing Controller

This block is the digital sequencer in front of a successive-approximation converter. An 8-bit mode register picks one of three trigger schemes (software start, hardware trigger with the converter already powered, or hardware trigger that powers the converter on demand). It also picks one-shot or repeated conversion and which of four hardware event lines acts as the trigger. The block issues a one-cycle start request and a power-up request to the analog side, and it takes back a one-cycle done pulse.

Hardware events pass through a two-register delay before they reach the sequencer. Two of the event sources are masked for a short window after each accepted pulse. Mode writes are refused while conversion is enabled, so the configuration cannot change under a running sequence.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, cfg_o reads 0x00, and conv_start_o and pwr_req_o are low while enable_i is low.
- R2: Mode layout: bits 7:6 set the trigger scheme (0x software, 10 hardware no-wait, 11 hardware wait). Bit 5 set to 1 selects one-shot and 0 selects repeated. Bits 4:2 always read 0. Bits 1:0 set the event source (00 line 0, 01 none, 10 line 2, 11 line 3).
- R3: A write on cfg_we_i updates cfg_o at the next edge only if start_i and enable_i are both low. Otherwise the write is dropped.
- R4: In software mode, the first edge at which start_i and enable_i are both high raises conv_start_o for exactly one cycle.
- R5: In software repeated mode, every done pulse sampled while start_i and enable_i stay high gives a new start at that same edge. In software one-shot mode there is no further start until start_i has been seen low.
- R6: In hardware no-wait mode, an event pulse on the selected line sampled at edge N raises conv_start_o at edge N+2. With no event there is no start.
- R7: Event lines other than the selected one never trigger, and source code 01 never triggers.
- R8: For sources 10 and 11, pulses sampled in the LOCK_CYC edges after an accepted pulse are ignored. Source 00 has no such window.
- R9: In hardware wait mode, pwr_req_o stays low until an event. It rises at edge N+2, and conv_start_o follows at edge N+2+STAB_CYC.
- R10: In wait mode, one-shot conversion drops pwr_req_o at the edge where done is sampled. In repeated conversion the request is kept, and the next event starts at N+2 with no stabilization wait.
- R11: An event that arrives while a stabilization wait or a conversion is in progress is discarded, and nothing is left pending.
- R12: In software and no-wait modes, pwr_req_o follows enable_i. When start_i or enable_i goes low, the sequencer returns to idle, no start is issued, and the wait-mode power request clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Mode register write strobe |
| cfg_wdata_i | input | 8 | Mode register write data |
| cfg_o | output | 8 | Mode register contents |
| start_i | input | 1 | Software conversion start bit |
| enable_i | input | 1 | Converter enable bit |
| hw_trig_i | input | 4 | Hardware event pulses, indexed by source code |
| conv_done_i | input | 1 | Conversion finished pulse from converter |
| conv_start_o | output | 1 | One-cycle conversion start request |
| pwr_req_o | output | 1 | Converter power-up request |

## Verification
The bench builds the block with STAB_CYC set to 3 and LOCK_CYC at its default of 4. It models the converter with a done latency it can change at run time. A one-cycle latency frees the sequencer before the lockout window ends, so the bench can tell a pulse masked by the lockout from one dropped because the sequencer is busy. A six-cycle latency keeps the sequencer busy long enough to show that an event arriving mid-conversion is discarded. The short stabilization count keeps the wait-mode power and start timing within a few edges of each event, so exact cycle checks are practical.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned CFG_W    = 8;
  localparam logic [7:0]  CFG_MASK = 8'hE3;
  localparam int unsigned TM_HI    = 7;
  localparam int unsigned TM_LO    = 6;
  localparam int unsigned ONE_BIT  = 5;
  localparam int unsigned N_SRC    = 4;
  localparam logic [1:0]  SRC_NONE = 2'b01;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STAB,
    ST_CONV,
    ST_HALT
  } seq_st_e;
endpackage

// File: rtl/adc_mode_reg.sv
module adc_mode_reg
  import adc_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             busy_i,
  output logic [CFG_W-1:0] cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cfg_o <= '0;
    else if (we_i && !busy_i) cfg_o <= wdata_i & CFG_MASK;
  end
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_seq_pkg::*;
#(
  parameter int unsigned LOCK_CYC = 4,
  localparam int unsigned LW      = $clog2(LOCK_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       src_i,
  input  logic [N_SRC-1:0] trig_i,
  output logic             trig_o
);
  logic [LW-1:0] lock_q;
  logic          raw, lock_src, acc, d1_q, d2_q;

  assign raw      = (src_i == SRC_NONE) ? 1'b0 : trig_i[src_i];
  assign lock_src = src_i[1];  // sources 10/11 carry the lockout
  assign acc      = raw && !(lock_src && (lock_q != '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= '0;
      d1_q   <= 1'b0;
      d2_q   <= 1'b0;
    end else begin
      if (acc && lock_src)   lock_q <= LW'(LOCK_CYC);
      else if (lock_q != '0) lock_q <= lock_q - 1'b1;
      d1_q <= acc;
      d2_q <= d1_q;
    end
  end

  assign trig_o = d2_q;
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int unsigned STAB_CYC = 8,
  localparam int unsigned SW      = $clog2(STAB_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  logic hw_mode_i,
  input  logic wait_mode_i,
  input  logic one_shot_i,
  input  logic trig_i,
  input  logic done_i,
  output logic start_o,
  output logic pwr_o
);
  seq_st_e       st_q;
  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      start_o <= 1'b0;
      pwr_o   <= 1'b0;
    end else begin
      start_o <= 1'b0;
      if (!go_i) begin
        st_q  <= ST_IDLE;
        pwr_o <= 1'b0;
      end else begin
        unique case (st_q)
          ST_IDLE: begin
            if (!hw_mode_i) begin
              start_o <= 1'b1;
              st_q    <= ST_CONV;
            end else if (trig_i) begin
              if (wait_mode_i && !pwr_o) begin
                pwr_o <= 1'b1;
                cnt_q <= '0;
                st_q  <= ST_STAB;
              end else begin
                start_o <= 1'b1;
                st_q    <= ST_CONV;
              end
            end
          end
          ST_STAB: begin
            if (cnt_q == SW'(STAB_CYC - 1)) begin
              start_o <= 1'b1;
              st_q    <= ST_CONV;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_CONV: begin
            if (done_i) begin
              if (one_shot_i) begin
                pwr_o <= 1'b0;
                st_q  <= hw_mode_i ? ST_IDLE : ST_HALT;
              end else if (!hw_mode_i) begin
                start_o <= 1'b1;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          default: st_q <= ST_HALT;  // held until go drops
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned STAB_CYC = 8,
  parameter int unsigned LOCK_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_o,
  input  logic             start_i,
  input  logic             enable_i,
  input  logic [N_SRC-1:0] hw_trig_i,
  input  logic             conv_done_i,
  output logic             conv_start_o,
  output logic             pwr_req_o
);
  logic go, hw_mode, wait_mode, trig, pwr_wait;

  assign go        = start_i && enable_i;
  assign hw_mode   = cfg_o[TM_HI];
  assign wait_mode = cfg_o[TM_HI] && cfg_o[TM_LO];

  adc_mode_reg u_mode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .busy_i  (start_i || enable_i),
    .cfg_o   (cfg_o)
  );

  adc_trig_sel #(.LOCK_CYC(LOCK_CYC)) u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (cfg_o[1:0]),
    .trig_i (hw_trig_i),
    .trig_o (trig)
  );

  adc_seq_fsm #(.STAB_CYC(STAB_CYC)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go),
    .hw_mode_i   (hw_mode),
    .wait_mode_i (wait_mode),
    .one_shot_i  (cfg_o[ONE_BIT]),
    .trig_i      (trig),
    .done_i      (conv_done_i),
    .start_o     (conv_start_o),
    .pwr_o       (pwr_wait)
  );

  assign pwr_req_o = wait_mode ? pwr_wait : enable_i;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_we_i,
  input logic [7:0] cfg_wdata_i,
  input logic [7:0] cfg_o,
  input logic       start_i,
  input logic       enable_i,
  input logic [3:0] hw_trig_i,
  input logic       conv_done_i,
  input logic       conv_start_o,
  input logic       pwr_req_o
);
  p_wr_blocked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && (start_i || enable_i)) |=> $stable(cfg_o));

  p_wr_taken_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !start_i && !enable_i) |=> (cfg_o[4:2] == 3'b000));

  p_start_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);

  p_no_start_off_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_i && enable_i) |=> !conv_start_o);

  p_wait_pwr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_start_o && cfg_o[7:6] == 2'b11) |-> pwr_req_o);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (.*);

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int STAB = 3;
  localparam int LOCK = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [7:0] cfg_wdata_i = '0;
  logic [7:0] cfg_o;
  logic       start_i = 1'b0, enable_i = 1'b0;
  logic [3:0] hw_trig_i = '0;
  logic       conv_done_i = 1'b0;
  logic       conv_start_o, pwr_req_o;

  int cyc = 0, nstarts = 0, last_start = -1;
  int conv_lat = 4, dcnt = 0;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_ctrl #(.STAB_CYC(STAB), .LOCK_CYC(LOCK)) u_adc_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
    .cfg_o(cfg_o), .start_i(start_i), .enable_i(enable_i), .hw_trig_i(hw_trig_i),
    .conv_done_i(conv_done_i), .conv_start_o(conv_start_o), .pwr_req_o(pwr_req_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (conv_start_o) begin
      nstarts = nstarts + 1;
      last_start = cyc;
    end
    conv_done_i = 1'b0;
    if (conv_start_o) dcnt = conv_lat;
    else if (dcnt > 0) begin
      dcnt = dcnt - 1;
      if (dcnt == 0) conv_done_i = 1'b1;
    end
  end

  function automatic logic [7:0] exp_cfg(logic [7:0] old, logic [7:0] d, logic we, logic s, logic e);
    return (we && !s && !e) ? (d & 8'hE3) : old;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int k);
    repeat (k) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) idle(1);
  endtask

  task automatic wr(input logic [7:0] v);
    cfg_we_i = 1'b1; cfg_wdata_i = v;
    idle(1);
    cfg_we_i = 1'b0;
  endtask

  task automatic pulse(input int idx, output int n);
    hw_trig_i[idx] = 1'b1;
    idle(1);
    n = cyc;
    hw_trig_i = '0;
  endtask

  task automatic stop_all();
    start_i = 1'b0; enable_i = 1'b0;
    idle(12);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, m, s0;
    logic [7:0] model;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(cfg_o == 8'h00, "R1 cfg", cfg_o, 0);
    chk(!conv_start_o, "R1 start", conv_start_o, 0);
    chk(!pwr_req_o, "R1 pwr", pwr_req_o, 0);
    rst_ni = 1'b1;
    idle(1);

    // R2 reserved bits
    wr(8'hFF);
    chk(cfg_o == 8'hE3, "R2 mask", cfg_o, 8'hE3);

    // R3 random writes under random start/enable
    model = cfg_o;
    for (int i = 0; i < 300; i++) begin
      int r;
      logic [7:0] d;
      r = $urandom % 4;
      d = 8'($urandom);
      start_i = (r == 1 || r == 3);
      enable_i = (r >= 2);
      cfg_we_i = 1'b1; cfg_wdata_i = d;
      idle(1);
      cfg_we_i = 1'b0;
      model = exp_cfg(model, d, 1'b1, start_i, enable_i);
      chk(cfg_o == model, "R3 write gate", cfg_o, model);
    end
    stop_all();

    // R4/R5/R12 software repeated
    wr(8'h00);
    enable_i = 1'b1;
    idle(1);
    chk(pwr_req_o, "R12 pwr follows enable", pwr_req_o, 1);
    s0 = nstarts;
    start_i = 1'b1;
    idle(1);
    n = cyc;
    chk(conv_start_o, "R4 sw start", conv_start_o, 1);
    wait_to(n + 12);
    chk(nstarts - s0 == 3, "R5 sw repeat count", nstarts - s0, 3);
    chk(last_start == n + 10, "R5 sw restart edge", last_start, n + 10);
    start_i = 1'b0;
    wait_to(n + 24);
    chk(nstarts - s0 == 3, "R12 stop on start low", nstarts - s0, 3);
    stop_all();

    // R5 software one-shot
    wr(8'h20);
    s0 = nstarts;
    enable_i = 1'b1; start_i = 1'b1;
    idle(16);
    chk(nstarts - s0 == 1, "R5 one-shot single", nstarts - s0, 1);
    start_i = 1'b0; idle(1);
    start_i = 1'b1; idle(1);
    chk(conv_start_o, "R5 one-shot rearm", conv_start_o, 1);
    stop_all();

    // R6 hardware no-wait, source 00
    wr(8'h80);
    enable_i = 1'b1; start_i = 1'b1;
    s0 = nstarts;
    idle(4);
    chk(nstarts == s0, "R6 no event no start", nstarts - s0, 0);
    chk(pwr_req_o, "R12 no-wait pwr", pwr_req_o, 1);
    pulse(0, n);
    idle(1);
    chk(!conv_start_o, "R6 not at N+1", conv_start_o, 0);
    idle(1);
    chk(conv_start_o, "R6 start at N+2", conv_start_o, 1);
    wait_to(n + 12);
    chk(nstarts - s0 == 1, "R6 hw waits next event", nstarts - s0, 1);

    // R7 other lines ignored
    s0 = nstarts;
    pulse(2, n); pulse(3, n); pulse(1, n);
    idle(6);
    chk(nstarts == s0, "R7 unselected lines", nstarts - s0, 0);
    stop_all();
    wr(8'h81);
    enable_i = 1'b1; start_i = 1'b1;
    s0 = nstarts;
    for (int k = 0; k < 4; k++) begin pulse(k, n); idle(6); end
    chk(nstarts == s0, "R7 source 01 inert", nstarts - s0, 0);
    stop_all();

    // R8 lockout on source 11, none on 00
    conv_lat = 1;
    wr(8'h83);
    enable_i = 1'b1; start_i = 1'b1;
    s0 = nstarts;
    idle(2);
    pulse(3, n);
    wait_to(n + 3);
    pulse(3, m);  // at n+4: locked
    pulse(3, m);  // at n+5: accepted
    wait_to(n + 12);
    chk(nstarts - s0 == 2, "R8 lockout count", nstarts - s0, 2);
    chk(last_start == n + 7, "R8 post-lock start", last_start, n + 7);
    stop_all();
    wr(8'h80);
    enable_i = 1'b1; start_i = 1'b1;
    s0 = nstarts;
    idle(2);
    pulse(0, n);
    wait_to(n + 3);
    pulse(0, m);
    wait_to(n + 12);
    chk(nstarts - s0 == 2, "R8 source 00 no lock", nstarts - s0, 2);
    chk(last_start == n + 6, "R8 source 00 edge", last_start, n + 6);

    // R11 event during conversion dropped
    conv_lat = 6;
    s0 = nstarts;
    pulse(0, n);
    wait_to(n + 2);
    pulse(0, m);
    wait_to(n + 14);
    chk(nstarts - s0 == 1, "R11 busy drop", nstarts - s0, 1);
    pulse(0, n);
    wait_to(n + 4);
    chk(last_start == n + 2, "R11 nothing pending", last_start, n + 2);
    stop_all();

    // R9/R10 wait mode one-shot, source 10
    conv_lat = 4;
    wr(8'hE2);
    enable_i = 1'b1; start_i = 1'b1;
    idle(2);
    chk(!pwr_req_o, "R9 pwr low before event", pwr_req_o, 0);
    pulse(2, n);
    idle(1);
    chk(!pwr_req_o, "R9 pwr low at N+1", pwr_req_o, 0);
    idle(1);
    chk(pwr_req_o, "R9 pwr at N+2", pwr_req_o, 1);
    wait_to(n + 9);
    chk(last_start == n + 2 + STAB, "R9 start after stab", last_start, n + 2 + STAB);
    chk(pwr_req_o, "R10 pwr held in conv", pwr_req_o, 1);
    wait_to(n + 10);
    chk(!pwr_req_o, "R10 one-shot pwr drop", pwr_req_o, 0);
    stop_all();

    // R10 wait mode repeated
    wr(8'hC2);
    enable_i = 1'b1; start_i = 1'b1;
    idle(2);
    pulse(2, n);
    wait_to(n + 12);
    chk(pwr_req_o, "R10 repeat pwr kept", pwr_req_o, 1);
    pulse(2, m);
    wait_to(m + 4);
    chk(last_start == m + 2, "R10 no stab when powered", last_start, m + 2);
    wait_to(m + 10);
    start_i = 1'b0;
    idle(1);
    chk(!pwr_req_o, "R12 wait pwr clears", pwr_req_o, 0);
    stop_all();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule